// File: doc/BRIEF.md
# Effective Address Generator

This block forms the memory address for a load or store from the operands that the instruction decoder and register file supply. A 3-bit mode code selects how the address is built. The possible parts are a constant displacement from the instruction word, a base register value, and an index register value. The index can be scaled by 1, 2, 4 or 8, which suits arrays. The address space is flat, so the result is the linear address and needs no further translation.

The block has one registered stage. When `in_valid` is high, the operands are sampled on a rising clock edge. The address and its valid flag appear at the outputs on that same edge. All sums wrap modulo 2^32. The displacement is either used at full width or sign-extended from its low byte, as the instruction's encoding selects. Codes that name no mode give address zero.

Top module: `ea_gen`

## Requirements
- R1: During reset `out_valid` and `ea` are 0. After reset, `out_valid` is high in the cycle after each edge that samples `in_valid` high, and low after each edge that samples it low.
- R2: Mode code 3'd0 (direct) gives `ea` = the extended displacement. `base`, `index` and `scale` have no effect.
- R3: Mode code 3'd1 (register-indirect) gives `ea` = `base`. `disp`, `index` and `scale` have no effect.
- R4: Mode code 3'd2 gives `ea` = `base` + extended displacement.
- R5: Mode code 3'd3 gives `ea` = `base` + `index` + extended displacement, with `scale` ignored.
- R6: Mode code 3'd4 (scaled) gives `ea` = `base` + (`index` << `scale`), with the displacement ignored. Scale codes 0, 1, 2 and 3 mean factors 1, 2, 4 and 8.
- R7: Mode code 3'd5 gives `ea` = `base` + (`index` << `scale`) + extended displacement.
- R8: When `disp_wide` is 1, all 32 bits of `disp` are used. When it is 0, bits [7:0] are sign-extended from bit 7, and bits [31:8] are ignored.
- R9: Every sum wraps modulo 2^32, and bits shifted out of the scaled index are dropped.
- R10: Mode codes 3'd6 and 3'd7 give `ea` = 0, whatever the operands.
- R11: On an edge that samples `in_valid` low, `ea` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are valid this cycle |
| mode | input | 3 | Addressing-mode code |
| disp | input | 32 | Displacement from the instruction |
| disp_wide | input | 1 | 1: full 32-bit displacement; 0: sign-extend bits [7:0] |
| base | input | 32 | Base register value |
| index | input | 32 | Index register value |
| scale | input | 2 | Index shift amount (factor 1, 2, 4 or 8) |
| out_valid | output | 1 | `ea` holds a new result |
| ea | output | 32 | Effective (linear) address |

## Verification
The only state in the block is the output register and the valid flag. A wrong operand-select decode or a wrong shift amount therefore shows up as a wrong `ea` one cycle after the operands are sampled. The same is true of a wrong sign extension. Directed vectors make each operand's contribution distinct, so that dropping or adding any one term changes the address. Examples are a base of 0x1000 with an index of 0x10 at every scale, and displacements whose sign bit is set. Vectors that wrap past 2^32 and vectors with the unused mode codes cover the boundaries. Cycles with `in_valid` low show whether the register loads when it should not.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        AM_DIRECT        = 3'd0,
        AM_INDIRECT      = 3'd1,
        AM_BASE_DISP     = 3'd2,
        AM_BASE_IDX_DISP = 3'd3,
        AM_SCALED        = 3'd4,
        AM_SCALED_DISP   = 3'd5
    } am_e;

    // Which operands take part in the sum for a given mode.
    typedef struct packed {
        logic use_base;
        logic use_index;
        logic use_scale;
        logic use_disp;
    } am_ctl_t;

    function automatic am_ctl_t am_decode(logic [MODE_W-1:0] code);
        am_ctl_t c;
        c = '0;
        case (am_e'(code))
            AM_DIRECT:        c = '{use_base: 1'b0, use_index: 1'b0, use_scale: 1'b0, use_disp: 1'b1};
            AM_INDIRECT:      c = '{use_base: 1'b1, use_index: 1'b0, use_scale: 1'b0, use_disp: 1'b0};
            AM_BASE_DISP:     c = '{use_base: 1'b1, use_index: 1'b0, use_scale: 1'b0, use_disp: 1'b1};
            AM_BASE_IDX_DISP: c = '{use_base: 1'b1, use_index: 1'b1, use_scale: 1'b0, use_disp: 1'b1};
            AM_SCALED:        c = '{use_base: 1'b1, use_index: 1'b1, use_scale: 1'b1, use_disp: 1'b0};
            AM_SCALED_DISP:   c = '{use_base: 1'b1, use_index: 1'b1, use_scale: 1'b1, use_disp: 1'b1};
            default:          c = '0;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/ea_disp_ext.sv
module ea_disp_ext #(
    parameter int W  = 32,
    parameter int NW = 8
) (
    input  logic [W-1:0] disp,
    input  logic         wide,
    output logic [W-1:0] ext
);
    logic [W-1:0] narrow;

    generate
        if (NW < W) begin : g_sext
            assign narrow = {{(W-NW){disp[NW-1]}}, disp[NW-1:0]};
        end else begin : g_pass
            assign narrow = disp;
        end
    endgenerate

    assign ext = wide ? disp : narrow;
endmodule

// File: rtl/ea_index_scaler.sv
module ea_index_scaler #(
    parameter int W  = 32,
    parameter int SW = 2
) (
    input  logic [W-1:0]  idx,
    input  logic [SW-1:0] scale,
    input  logic          en,
    output logic [W-1:0]  scaled
);
    localparam int NSHIFT = 1 << SW;

    logic [W-1:0] cand [NSHIFT];

    generate
        for (genvar g = 0; g < NSHIFT; g++) begin : g_shift
            assign cand[g] = idx << g;
        end
    endgenerate

    assign scaled = en ? cand[scale] : idx;
endmodule

// File: rtl/ea_sum.sv
module ea_sum #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    input  logic         en_a,
    input  logic         en_b,
    input  logic         en_c,
    output logic [W-1:0] sum
);
    logic [W-1:0] ta, tb, tc;

    always_comb begin
        ta  = en_a ? a : '0;
        tb  = en_b ? b : '0;
        tc  = en_c ? c : '0;
        sum = ta + tb + tc;   // carry out of the top bit is dropped
    end
endmodule

// File: rtl/ea_gen.sv
module ea_gen #(
    parameter int ADDR_W        = 32,
    parameter int DISP_NARROW_W = 8,
    parameter int SCALE_W       = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [ea_pkg::MODE_W-1:0]  mode,
    input  logic [ADDR_W-1:0]          disp,
    input  logic                       disp_wide,
    input  logic [ADDR_W-1:0]          base,
    input  logic [ADDR_W-1:0]          index,
    input  logic [SCALE_W-1:0]         scale,
    output logic                       out_valid,
    output logic [ADDR_W-1:0]          ea
);
    import ea_pkg::*;

    am_ctl_t           ctl;
    logic [ADDR_W-1:0] disp_x;
    logic [ADDR_W-1:0] idx_s;
    logic [ADDR_W-1:0] sum;

    assign ctl = am_decode(mode);

    ea_disp_ext #(.W(ADDR_W), .NW(DISP_NARROW_W)) u_disp (
        .disp (disp),
        .wide (disp_wide),
        .ext  (disp_x)
    );

    ea_index_scaler #(.W(ADDR_W), .SW(SCALE_W)) u_scale (
        .idx    (index),
        .scale  (scale),
        .en     (ctl.use_scale),
        .scaled (idx_s)
    );

    ea_sum #(.W(ADDR_W)) u_sum (
        .a    (base),
        .b    (idx_s),
        .c    (disp_x),
        .en_a (ctl.use_base),
        .en_b (ctl.use_index),
        .en_c (ctl.use_disp),
        .sum  (sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            ea        <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) ea <= sum;
        end
    end

    p_latency_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_direct_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 3'd0 && disp_wide) |=> ea == $past(disp));
    p_indirect_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 3'd1) |=> ea == $past(base));
    p_scaled_one_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 3'd4 && scale == '0) |=> ea == $past(base) + $past(index));
    p_unused_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode >= 3'd6) |=> ea == '0);
    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(ea));
endmodule

// File: tb/sim_ea_gen.sv
`timescale 1ns/1ps
module sim_ea_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  mode = '0;
    logic [31:0] disp = '0;
    logic        disp_wide = 1'b0;
    logic [31:0] base = '0;
    logic [31:0] index = '0;
    logic [1:0]  scale = '0;
    logic        out_valid;
    logic [31:0] ea;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    ea_gen u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
        .disp(disp), .disp_wide(disp_wide), .base(base), .index(index),
        .scale(scale), .out_valid(out_valid), .ea(ea)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Drive one operand set, wait for the edge, then check one cycle later.
    task automatic apply(string req, logic [2:0] m, logic [31:0] d, logic w,
                         logic [31:0] b, logic [31:0] x, logic [1:0] s,
                         logic [31:0] exp);
        @(negedge clk);
        mode = m; disp = d; disp_wide = w; base = b; index = x; scale = s;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, {31'b0, out_valid}, 32'd1);
        check(req, ea, exp);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 reset valid", {31'b0, out_valid}, 32'd0);
        check("R1 reset ea", ea, 32'd0);
        rst = 1'b0;
    endtask

    task automatic t_direct();
        apply("R2 direct wide", 3'd0, 32'h0000_2012, 1'b1, 32'h0000_FFFF, 32'h1234, 2'd3, 32'h0000_2012);
        apply("R8 direct narrow neg", 3'd0, 32'hABCD_12F0, 1'b0, 32'h5, 32'h6, 2'd1, 32'hFFFF_FFF0);
        apply("R8 direct narrow pos", 3'd0, 32'hFFFF_FF7F, 1'b0, 32'h0, 32'h0, 2'd0, 32'h0000_007F);
    endtask

    task automatic t_indirect();
        apply("R3 indirect", 3'd1, 32'h0000_0055, 1'b1, 32'h0000_200C, 32'h9, 2'd2, 32'h0000_200C);
    endtask

    task automatic t_base_disp();
        apply("R4 base+disp wide", 3'd2, 32'h0000_0012, 1'b1, 32'h0000_2000, 32'h77, 2'd1, 32'h0000_2012);
        apply("R4 base+disp narrow neg", 3'd2, 32'h1234_56FE, 1'b0, 32'h0000_2000, 32'h77, 2'd0, 32'h0000_1FFE);
    endtask

    task automatic t_base_idx_disp();
        apply("R5 base+idx+disp", 3'd3, 32'h0000_0004, 1'b1, 32'h0000_1000, 32'h20, 2'd3, 32'h0000_1024);
    endtask

    task automatic t_scaled();
        for (int s = 0; s < 4; s++) begin
            apply("R6 scaled", 3'd4, 32'h0000_0999, 1'b1, 32'h0000_1000, 32'h10, 2'(s),
                  32'h0000_1000 + (32'h10 << s));
        end
    endtask

    task automatic t_scaled_disp();
        apply("R7 scaled+disp narrow", 3'd5, 32'h0000_00FC, 1'b0, 32'h0000_1000, 32'h3, 2'd2, 32'h0000_1008);
        apply("R7 scaled+disp wide", 3'd5, 32'h0001_0000, 1'b1, 32'h0000_1000, 32'h3, 2'd3, 32'h0001_1018);
    endtask

    task automatic t_wrap();
        apply("R9 wrap add", 3'd2, 32'h0000_0020, 1'b1, 32'hFFFF_FFF0, 32'h0, 2'd0, 32'h0000_0010);
        apply("R9 wrap shift", 3'd4, 32'h0, 1'b1, 32'h0, 32'h8000_0001, 2'd1, 32'h0000_0002);
        apply("R9 wrap three", 3'd3, 32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFF, 32'h2, 2'd0, 32'h0000_0000);
    endtask

    task automatic t_unused();
        apply("R10 mode 6", 3'd6, 32'h1111_1111, 1'b1, 32'h2222_2222, 32'h3, 2'd1, 32'h0);
        apply("R10 mode 7", 3'd7, 32'h0000_00FF, 1'b0, 32'h4444_0000, 32'h5, 2'd3, 32'h0);
    endtask

    task automatic t_hold();
        apply("R11 setup", 3'd1, 32'h0, 1'b1, 32'hCAFE_0000, 32'h0, 2'd0, 32'hCAFE_0000);
        @(negedge clk);
        mode = 3'd2; base = 32'h1; disp = 32'h1; disp_wide = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 idle valid", {31'b0, out_valid}, 32'd0);
        check("R11 hold ea", ea, 32'hCAFE_0000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_direct();
        t_indirect();
        t_base_disp();
        t_base_idx_disp();
        t_scaled();
        t_scaled_disp();
        t_wrap();
        t_unused();
        t_hold();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule